// File: doc/BRIEF.md
# Chained Converter Serial Port with Busy-Done Flag

This block is the digital side of one sampling converter's serial port, in the variant where several converters are cascaded into a single long shift register. A host raises the convert strobe while the serial clock is high. That starts a timed conversion and arms chained readback. When the conversion timer expires, the block latches a 16-bit parallel sample. From then on its serial output repeats the level on its serial input, so a completion flag ripples toward the host only after every converter in the chain has finished. The far end of the chain has its serial input tied to the strobe, which is high.

The host spends one extra serial-clock falling edge to consume the flag. Each later falling edge then moves one bit. The local result leaves first, most significant bit first, and the bits from upstream follow it. All pins are sampled on a fast system clock, and their edges are found by comparing successive synchronised values. Dropping the strobe returns the port to idle at any time.

Top module: `chain_adc_port`

## Requirements
- R1: While the convert strobe and the serial input are both low, the serial output is low. It is also low in idle and throughout a conversion.
- R2: A rising strobe edge seen while the serial clock is high starts a conversion in chained mode.
- R3: A rising strobe edge seen while the serial clock is low starts nothing. The serial output stays low, whatever the serial input does and however the clock toggles.
- R4: A conversion lasts exactly CONV_CYCLES system clocks after it starts. The serial output stays low until the conversion ends.
- R5: From the end of a conversion until the first serial-clock falling edge, the serial output follows the serial input. This is the busy-done flag.
- R6: The parallel sample is captured at the end of the conversion. Changes to it afterwards do not reach the output.
- R7: After the flag edge, the serial output shows the captured sample, most significant bit first. Each further serial-clock falling edge advances it by one bit.
- R8: The bits taken from the serial input on those falling edges follow the 16 local bits on the output, in the order they arrived.
- R9: Serial-clock edges that occur during a conversion move no data.
- R10: A falling strobe edge returns the port to idle and clears chained mode, with the output low. It takes priority over a conversion ending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert strobe |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial input from the upstream converter |
| sample_i | input | 16 | Parallel conversion result |
| sdo_o | output | 1 | Serial output toward the host |

## Verification
Two events can land in the same system clock: the conversion timer expiring and the detection of a falling strobe edge. The bench lowers the strobe exactly CONV_CYCLES clocks after raising it. With two synchronising stages in front of both detectors, the two events then coincide. The falling edge must win. The output must stay low even with the serial input held high, and a later conversion must still start and raise its flag on time.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } port_state_e;
endpackage

// File: rtl/chain_pin_sync.sv
// Per-pin synchroniser with edge detection on the synchronised value.
module chain_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], pin_i[b]};
        prev_q <= sync_q[STAGES-1];
      end
    end
    assign lvl_o[b]  = sync_q[STAGES-1];
    assign rise_o[b] = sync_q[STAGES-1] & ~prev_q;
    assign fall_o[b] = ~sync_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/chain_conv_timer.sv
// Fixed-length conversion timer with abort.
module chain_conv_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (abort_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i) |=> (busy_q && cnt_q == '0));
  assert_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !abort_i && !start_i) |=> !busy_q);
endmodule

// File: rtl/chain_shifter.sv
// Result register: parallel load, serial shift toward the MSB.
module chain_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic             shift_i,
  input  logic             ser_i,
  output logic             msb_o
);
  logic [WIDTH-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)       sr_d = load_data_i;
    else if (shift_i) sr_d = {sr_q[WIDTH-2:0], ser_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb_o = sr_q[WIDTH-1];

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sr_q == $past(load_data_i)));
  assert_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (sr_q[0] == $past(ser_i) && sr_q[WIDTH-1:1] == $past(sr_q[WIDTH-2:0])));
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port
  import chain_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o
);
  localparam int PIN_CNV = 0;
  localparam int PIN_SCK = 1;
  localparam int PIN_SDI = 2;
  localparam int NPINS   = 3;

  logic [NPINS-1:0] lvl, rise, fall;
  logic cnv_lvl, cnv_rise, cnv_fall, sck_lvl, sck_fall, sdi_lvl;

  chain_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({sdi_i, sck_i, cnv_i}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign cnv_lvl  = lvl[PIN_CNV];
  assign cnv_rise = rise[PIN_CNV];
  assign cnv_fall = fall[PIN_CNV];
  assign sck_lvl  = lvl[PIN_SCK];
  assign sck_fall = fall[PIN_SCK];
  assign sdi_lvl  = lvl[PIN_SDI];

  port_state_e st_q, st_d;
  logic chain_q, chain_d;
  logic arm_q, arm_d;
  logic tmr_start, tmr_abort, tmr_done;
  logic sh_load, sh_shift, sh_msb;

  chain_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(tmr_start),
    .abort_i(tmr_abort),
    .done_o (tmr_done)
  );

  chain_shifter #(.WIDTH(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (sh_load),
    .load_data_i(sample_i),
    .shift_i    (sh_shift),
    .ser_i      (sdi_lvl),
    .msb_o      (sh_msb)
  );

  always_comb begin
    st_d      = st_q;
    chain_d   = chain_q;
    arm_d     = arm_q;
    tmr_start = 1'b0;
    tmr_abort = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    if (cnv_fall) begin
      st_d      = ST_IDLE;
      chain_d   = 1'b0;
      arm_d     = 1'b0;
      tmr_abort = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cnv_rise && sck_lvl) begin
          st_d      = ST_CONV;
          chain_d   = 1'b1;
          tmr_start = 1'b1;
        end
        ST_CONV: if (tmr_done) begin
          st_d    = ST_READ;
          sh_load = 1'b1;
          arm_d   = 1'b1;
        end
        ST_READ: if (sck_fall) begin
          if (arm_q) arm_d    = 1'b0;
          else       sh_shift = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      chain_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      chain_q <= chain_d;
      arm_q   <= arm_d;
    end
  end

  assign sdo_o = (st_q == ST_READ && chain_q) ? (arm_q ? sdi_lvl : sh_msb) : 1'b0;

  assert_low_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnv_lvl && !sdi_lvl) |=> !sdo_o);
  assert_chain_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cnv_rise && sck_lvl) |=> (st_q == ST_CONV && chain_q));
  assert_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cnv_rise && !sck_lvl) |=> (st_q == ST_IDLE));
  assert_conv_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONV && !cnv_fall && !tmr_done) |=> (st_q == ST_CONV && !sdo_o));
  assert_fall_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_fall |=> (st_q == ST_IDLE && !chain_q && !sdo_o));
endmodule

// File: tb/chain_adc_port_tb_top.sv
module chain_adc_port_tb_top;
  localparam int C = 40;
  localparam int NV = 4;
  // each entry: {local sample, upstream bits}
  localparam logic [31:0] VEC [NV] = '{
    32'hA5C3_0F0F, 32'hFFFF_0000, 32'h0001_8000, 32'h7E81_C3A5};

  logic clk = 1'b0;
  logic rst_n, cnv, sck, sdi;
  logic [15:0] sample;
  logic sdo;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chain_adc_port #(.DATA_W(16), .CONV_CYCLES(C), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi),
    .sample_i(sample), .sdo_o(sdo));

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: sdo=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_sck();
    sck = 1'b0; clks(4);
    sck = 1'b1; clks(4);
  endtask

  task automatic do_read(input logic [15:0] smp, input logic [15:0] up, input bit wig);
    logic [15:0] exp_bit;
    sample = smp; sck = 1'b1; sdi = 1'b1; cnv = 1'b0; clks(4);
    cnv = 1'b1;                              // R2: rise with clock high
    if (wig) begin                           // R9: clock edges during conversion
      clks(2); sck = 1'b0; clks(3); sck = 1'b1; clks(3);
      sck = 1'b0; clks(3); sck = 1'b1; clks(3);
      clks(2 + C - 14);
    end else clks(2 + C);
    chk("R4 still converting", sdo, 1'b0);
    clks(1);
    chk("R5 done flag", sdo, 1'b1);
    sample = ~smp;                           // R6: late change ignored
    sdi = 1'b0; clks(3);
    chk("R5 flag follows input", sdo, 1'b0);
    sdi = 1'b1; clks(3);
    chk("R5 flag follows input high", sdo, 1'b1);
    pulse_sck();                             // consumes the flag
    for (int i = 0; i < 32; i++) begin
      exp_bit = (i < 16) ? smp : up;
      if (i < 16) chk("R7 local bit", sdo, exp_bit[15 - i]);
      else        chk("R8 forwarded bit", sdo, exp_bit[31 - i]);
      sdi = (i < 16) ? up[15 - i] : 1'b0;
      clks(1);
      pulse_sck();
    end
    cnv = 1'b0; sdi = 1'b1; clks(5);
    chk("R10 idle after strobe fall", sdo, 1'b0);
    sdi = 1'b0; clks(4);
    chk("R1 both low", sdo, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: sdo=%b expected completion", sdo);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnv = 1'b0; sck = 1'b1; sdi = 1'b0; sample = 16'h0;
    clks(3);
    chk("R1 reset state", sdo, 1'b0);
    rst_n = 1'b1; clks(4);
    chk("R1 after reset", sdo, 1'b0);

    for (int v = 0; v < NV; v++)
      do_read(VEC[v][31:16], VEC[v][15:0], v[0]);

    // R3: rise with clock low starts nothing
    sck = 1'b0; sdi = 1'b0; clks(4);
    cnv = 1'b1; clks(C + 10);
    sdi = 1'b1; clks(4);
    chk("R3 no conversion", sdo, 1'b0);
    pulse_sck(); pulse_sck();
    chk("R3 clocking ignored", sdo, 1'b0);
    cnv = 1'b0; clks(5);

    // R10: strobe fall coinciding with conversion end
    sck = 1'b1; sdi = 1'b1; sample = 16'hFFFF; clks(4);
    cnv = 1'b1; clks(C);
    cnv = 1'b0; clks(1);
    chk("R10 coincident fall, early", sdo, 1'b0);
    clks(6);
    chk("R10 coincident fall wins", sdo, 1'b0);
    cnv = 1'b1; clks(3 + C);
    chk("R2 restart after abort", sdo, 1'b1);
    pulse_sck();
    chk("R7 restart MSB", sdo, 1'b1);
    cnv = 1'b0; clks(5);
    chk("R10 final idle", sdo, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule